// File: doc/BRIEF.md
# Two-Wire Serial Register Slave

This block is the slave end of a two-wire serial bus. It lets an external master read and write a byte-wide register space through a 16-bit register pointer. The clock and data lines come straight from the pads. Each line passes through a two-flop synchroniser, and the block finds edges and bus conditions on the fast system clock, which must run at least eight times faster than the serial clock. The block never drives the clock line. It pulls the data line low through an open-drain enable when it acknowledges a byte or sends a zero bit, and leaves the line released at all other times.

A transaction opens with a start condition and an address byte. The upper seven bits of that byte are the device address and the lowest bit is the direction. In a write, the first two bytes after the address load the pointer, high byte first. Every byte after those is written to the register array at the pointer, and the pointer then advances by one. In a read, the block shifts out the byte at the pointer, most significant bit first, and keeps going while the master acknowledges. The pointer survives stop conditions, so a read with no pointer-setting write returns data from wherever the last access left off. A random-location read is a write that carries only the pointer, then a repeated start, then a read address byte.

The back end is a plain synchronous port. Read data is taken combinationally from the array at `rd_addr`. A write is a one-cycle strobe that carries its own address and data.

Top module: `twsr_slave`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sda_oe` and `wr_en` are 0 and `rd_addr` is 0x0000.
- R2: A falling data edge while the clock is high starts a transaction. A rising data edge while the clock is high ends it and releases the data line. With the default address, an address byte of 0x20 (write) is acknowledged by pulling data low in the ninth clock period.
- R3: When both `alt_en` and `alt_sel` are 1, the device address becomes 0x18, so 0x30 and 0x31 are accepted and 0x20 is not acknowledged. If either input is 0, the default 0x10 (0x20 and 0x21) applies.
- R4: When `prog_vld` is 1, the device address is `prog_addr`, and this takes priority over the pin-selected alternate.
- R5: In a write, the first message byte loads pointer bits [15:8] and the second loads bits [7:0]. Each later byte gives one `wr_en` pulse with `wr_addr` equal to the pointer and `wr_data` equal to the byte, after which the pointer has advanced by 1. Every byte is acknowledged.
- R6: In a read, the byte at `rd_addr` is shifted out most significant bit first. After a master acknowledge the next byte follows. After a no-acknowledge the data line stays released.
- R7: The pointer increments once for every byte read or written, and keeps its value across stop conditions. A read that opens with no pointer write returns the byte at the current pointer.
- R8: A write holding only the two pointer bytes, followed by a repeated start and a read address byte, reads from the new pointer and causes no `wr_en` pulse.
- R9: `sda_oe` changes only while the synchronised clock is low.
- R10: A start or stop in the middle of a byte abandons that byte. No `wr_en` pulse follows, the pointer is unchanged, and after a start the next byte is taken as an address byte.
- R11: An address byte whose upper seven bits do not match the device address is not acknowledged, and the block ignores the bus until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock from the pad |
| sda_in | input | 1 | Serial data from the pad (resolved bus level) |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| alt_en | input | 1 | Enables the pin-selected alternate address |
| alt_sel | input | 1 | Selects the alternate address when enabled |
| prog_vld | input | 1 | Use the programmed address |
| prog_addr | input | 7 | Programmed 7-bit device address |
| rd_addr | output | 16 | Current register pointer, read address of the array |
| rd_data | input | 8 | Array byte at `rd_addr` |
| wr_en | output | 1 | One-cycle write strobe |
| wr_addr | output | 16 | Write address |
| wr_data | output | 8 | Write data |

## Verification
A wrong internal state shows up at the ports within one serial byte. An acknowledge or data bit in the wrong clock period appears on `sda_oe` at the next falling serial clock. A miscounted bit moves the acknowledge and corrupts the byte the master assembles. A pointer error shows on `rd_addr` as soon as the byte completes, and the next current-location read returns the wrong value. A partial byte that is committed in error appears as a `wr_en` pulse, or as a moved `rd_addr`, once the stop has been seen.

// File: rtl/twsr_pkg.sv
package twsr_pkg;
    localparam int PTR_W  = 16;
    localparam int DATA_W = 8;
    localparam int BIT_W  = $clog2(DATA_W);
    localparam int HALF_W = PTR_W / 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_ACK_WAIT,
        S_ACK,
        S_TX,
        S_TX_ACK,
        S_TX_LOAD
    } state_e;

    typedef struct packed {
        state_e              state;
        logic [BIT_W-1:0]    bitcnt;
        logic [DATA_W-1:0]   shreg;
        logic                rw;
        logic [1:0]          bidx;
        logic [PTR_W-1:0]    ptr;
        logic                oe;
        logic                wen;
        logic [PTR_W-1:0]    waddr;
        logic [DATA_W-1:0]   wdata;
    } fsm_t;
endpackage

// File: rtl/twsr_sync.sv
module twsr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic prev
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-1:0], din};
    end

    assign lvl  = sh_q[STAGES-1];
    assign prev = sh_q[STAGES];
endmodule

// File: rtl/twsr_cond.sv
module twsr_cond (
    input  logic scl_lvl,
    input  logic scl_prev,
    input  logic sda_lvl,
    input  logic sda_prev,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_held;

    assign scl_held  = scl_lvl & scl_prev;
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_det = scl_held & sda_prev & ~sda_lvl;
    assign stop_det  = scl_held & ~sda_prev & sda_lvl;
endmodule

// File: rtl/twsr_addr_sel.sv
module twsr_addr_sel #(
    parameter logic [6:0] DEF_ADDR = 7'h10,
    parameter logic [6:0] ALT_ADDR = 7'h18
) (
    input  logic       alt_en,
    input  logic       alt_sel,
    input  logic       prog_vld,
    input  logic [6:0] prog_addr,
    output logic [6:0] dev_addr
);
    always_comb begin
        if (prog_vld)               dev_addr = prog_addr;
        else if (alt_en && alt_sel) dev_addr = ALT_ADDR;
        else                        dev_addr = DEF_ADDR;
    end
endmodule

// File: rtl/twsr_slave.sv
module twsr_slave
    import twsr_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEF_ADDR    = 7'h10,
    parameter logic [6:0] ALT_ADDR    = 7'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic              alt_en,
    input  logic              alt_sel,
    input  logic              prog_vld,
    input  logic [6:0]        prog_addr,
    output logic [PTR_W-1:0]  rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int              NLINES   = 2;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    logic [NLINES-1:0] pins, lvl, prv;
    logic scl_rise, scl_fall, start_det, stop_det;
    logic [6:0] dev_addr;
    logic [DATA_W-1:0] rx_byte;
    fsm_t q, d;

    assign pins = {sda_in, scl_in};

    for (genvar g = 0; g < NLINES; g++) begin : g_sync
        twsr_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (pins[g]),
            .lvl  (lvl[g]),
            .prev (prv[g])
        );
    end

    twsr_cond u_cond (
        .scl_lvl  (lvl[0]),
        .scl_prev (prv[0]),
        .sda_lvl  (lvl[1]),
        .sda_prev (prv[1]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    twsr_addr_sel #(.DEF_ADDR(DEF_ADDR), .ALT_ADDR(ALT_ADDR)) u_asel (
        .alt_en   (alt_en),
        .alt_sel  (alt_sel),
        .prog_vld (prog_vld),
        .prog_addr(prog_addr),
        .dev_addr (dev_addr)
    );

    assign rx_byte = {q.shreg[DATA_W-2:0], lvl[1]};

    always_comb begin
        d     = q;
        d.wen = 1'b0;
        if (start_det) begin
            d.state  = S_RX;
            d.bitcnt = '0;
            d.bidx   = '0;
            d.oe     = 1'b0;
        end else if (stop_det) begin
            d.state = S_IDLE;
            d.oe    = 1'b0;
        end else begin
            unique case (q.state)
                S_IDLE: ;
                S_RX: if (scl_rise) begin
                    d.shreg  = rx_byte;
                    d.bitcnt = q.bitcnt + 1'b1;
                    if (q.bitcnt == LAST_BIT) begin
                        d.state = S_ACK_WAIT;
                        if (q.bidx != 2'd3) d.bidx = q.bidx + 1'b1;
                        unique case (q.bidx)
                            2'd0: begin
                                if (rx_byte[DATA_W-1:1] == dev_addr) d.rw = rx_byte[0];
                                else                                 d.state = S_IDLE;
                            end
                            2'd1: d.ptr[PTR_W-1:HALF_W] = rx_byte;
                            2'd2: d.ptr[HALF_W-1:0]     = rx_byte;
                            default: begin
                                d.wen   = 1'b1;
                                d.waddr = q.ptr;
                                d.wdata = rx_byte;
                                d.ptr   = q.ptr + 1'b1;
                            end
                        endcase
                    end
                end
                S_ACK_WAIT: if (scl_fall) begin
                    d.oe    = 1'b1;
                    d.state = S_ACK;
                end
                S_ACK: if (scl_fall) begin
                    d.bitcnt = '0;
                    if (q.rw) begin
                        d.state = S_TX;
                        d.shreg = rd_data;
                        d.oe    = ~rd_data[DATA_W-1];
                    end else begin
                        d.state = S_RX;
                        d.oe    = 1'b0;
                    end
                end
                S_TX: if (scl_fall) begin
                    if (q.bitcnt == LAST_BIT) begin
                        d.oe    = 1'b0;
                        d.state = S_TX_ACK;
                        d.ptr   = q.ptr + 1'b1;
                    end else begin
                        d.bitcnt = q.bitcnt + 1'b1;
                        d.shreg  = q.shreg << 1;
                        d.oe     = ~q.shreg[DATA_W-2];
                    end
                end
                S_TX_ACK: if (scl_rise) begin
                    d.state = lvl[1] ? S_IDLE : S_TX_LOAD;
                end
                S_TX_LOAD: if (scl_fall) begin
                    d.state  = S_TX;
                    d.bitcnt = '0;
                    d.shreg  = rd_data;
                    d.oe     = ~rd_data[DATA_W-1];
                end
                default: d.state = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe  = q.oe;
    assign rd_addr = q.ptr;
    assign wr_en   = q.wen;
    assign wr_addr = q.waddr;
    assign wr_data = q.wdata;
endmodule

// File: rtl/twsr_slave_chk.sv
module twsr_slave_chk
    import twsr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             scl_s,
    input logic             start_det,
    input logic             stop_det,
    input logic             sda_oe,
    input logic             wr_en,
    input logic [PTR_W-1:0] wr_addr,
    input logic [PTR_W-1:0] ptr,
    input state_e           state
);
    // R9
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) && !$past(start_det) && !$past(stop_det) |-> !scl_s);

    // R6
    oe_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (state == S_ACK || state == S_TX));

    // R5
    wr_ptr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (ptr == PTR_W'(wr_addr + 1'b1)));

    // R2
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R10
    start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (!sda_oe && !wr_en));
endmodule

bind twsr_slave twsr_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (lvl[0]),
    .start_det(start_det),
    .stop_det (stop_det),
    .sda_oe   (sda_oe),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .ptr      (q.ptr),
    .state    (q.state)
);

// File: tb/sim_twsr_slave.sv
module sim_twsr_slave;
    localparam int CLK_P = 10;
    localparam int H     = 10;
    localparam int NVEC  = 8;
    localparam int WDOG  = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic sda_oe, sda_bus;
    logic alt_en = 1'b0, alt_sel = 1'b0, prog_vld = 1'b0;
    logic [6:0] prog_addr = 7'h00;
    logic [15:0] rd_addr, wr_addr;
    logic [7:0] rd_data, wr_data;
    logic wr_en;
    logic [7:0] mem [256];
    int wcount = 0;
    logic [15:0] last_waddr = 16'h0;
    int checks = 0, errors = 0;

    always #(CLK_P/2) clk = ~clk;
    assign sda_bus = m_sda & ~sda_oe;
    assign rd_data = mem[rd_addr[7:0]];

    twsr_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus), .sda_oe(sda_oe),
        .alt_en(alt_en), .alt_sel(alt_sel), .prog_vld(prog_vld), .prog_addr(prog_addr),
        .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h3C;

    always @(posedge clk) if (wr_en) begin
        mem[wr_addr[7:0]] <= wr_data;
        wcount <= wcount + 1;
        last_waddr <= wr_addr;
    end

    // {alt_en, alt_sel, prog_vld, prog_addr[6:0], addr_byte[7:0], expect_ack}
    localparam logic [18:0] VEC [NVEC] = '{
        {3'b000, 7'h00, 8'h20, 1'b1},  // R2 default write address
        {3'b000, 7'h00, 8'h30, 1'b0},  // R11 mismatch
        {3'b100, 7'h00, 8'h20, 1'b1},  // R3 enabled, not selected
        {3'b010, 7'h00, 8'h20, 1'b1},  // R3 selected, not enabled
        {3'b110, 7'h00, 8'h30, 1'b1},  // R3 alternate accepted
        {3'b110, 7'h00, 8'h20, 1'b0},  // R3 default refused
        {3'b001, 7'h2A, 8'h54, 1'b1},  // R4 programmed
        {3'b111, 7'h2A, 8'h30, 1'b0}   // R4 priority over pin
    };

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; waitc(H);
        m_scl = 1'b1; waitc(H);
        m_sda = 1'b0; waitc(H);
        m_scl = 1'b0; waitc(2);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; waitc(H);
        m_scl = 1'b1; waitc(H);
        m_sda = 1'b1; waitc(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; waitc(H - 2);
            m_scl = 1'b1; waitc(H);
            m_scl = 1'b0; waitc(2);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        m_sda = 1'b1; waitc(H - 2);
        m_scl = 1'b1; waitc(H / 2);
        ack = ~sda_bus; waitc(H / 2);
        m_scl = 1'b0; waitc(2);
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] v);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            waitc(H - 2);
            m_scl = 1'b1; waitc(H / 2);
            v[i] = sda_bus; waitc(H / 2);
            m_scl = 1'b0; waitc(2);
        end
        m_sda = ~give_ack; waitc(H - 2);
        m_scl = 1'b1; waitc(H);
        m_scl = 1'b0; waitc(2);
        m_sda = 1'b1;
    endtask

    initial begin
        logic ack;
        logic [7:0] v;
        int wbase;
        waitc(3);
        // R1 reset state
        chk("R1 sda_oe", 16'(sda_oe), 16'h0);
        chk("R1 wr_en", 16'(wr_en), 16'h0);
        chk("R1 rd_addr", rd_addr, 16'h0);
        rst_n = 1'b1;
        waitc(1);
        chk("R1 sda_oe after release", 16'(sda_oe), 16'h0);
        waitc(5);

        // address table
        for (int k = 0; k < NVEC; k++) begin
            {alt_en, alt_sel, prog_vld, prog_addr} = VEC[k][18:9];
            bus_start();
            send_byte(VEC[k][8:1], ack);
            chk($sformatf("R2/R3/R4/R11 addr vector %0d", k), 16'(ack), 16'(VEC[k][0]));
            bus_stop();
            chk("R2 released after stop", 16'(sda_oe), 16'h0);
        end
        {alt_en, alt_sel, prog_vld, prog_addr} = 10'h0;

        // R11 mismatch ignores following bytes
        wbase = wcount;
        bus_start();
        send_byte(8'h40, ack);
        send_byte(8'h00, ack);
        chk("R11 later byte not acked", 16'(ack), 16'h0);
        bus_stop();
        chk("R11 no write", 16'(wcount - wbase), 16'h0);

        // R5 write with pointer load and increment across boundary
        wbase = wcount;
        bus_start();
        send_byte(8'h20, ack); chk("R5 addr ack", 16'(ack), 16'h1);
        send_byte(8'h12, ack); chk("R5 ptr hi ack", 16'(ack), 16'h1);
        send_byte(8'hFE, ack); chk("R5 ptr lo ack", 16'(ack), 16'h1);
        chk("R5 pointer loaded", rd_addr, 16'h12FE);
        send_byte(8'hA5, ack); chk("R5 data ack", 16'(ack), 16'h1);
        send_byte(8'h5A, ack);
        send_byte(8'hC3, ack);
        bus_stop();
        chk("R5 write count", 16'(wcount - wbase), 16'h3);
        chk("R5 last write addr", last_waddr, 16'h1300);
        chk("R5 data at FE", 16'(mem[8'hFE]), 16'h00A5);
        chk("R5 data at 00", 16'(mem[8'h00]), 16'h00C3);
        chk("R7 pointer kept after stop", rd_addr, 16'h1301);

        // R7 current-location read
        bus_start();
        send_byte(8'h21, ack); chk("R7 read addr ack", 16'(ack), 16'h1);
        read_byte(1'b0, v);
        chk("R7 current read data", 16'(v), 16'h003D);
        waitc(4);
        chk("R6 released after nack", 16'(sda_oe), 16'h0);
        bus_stop();
        chk("R7 pointer after read", rd_addr, 16'h1302);

        // R8 random-location read with repeated start
        wbase = wcount;
        bus_start();
        send_byte(8'h20, ack);
        send_byte(8'h12, ack);
        send_byte(8'hFE, ack);
        bus_start();
        send_byte(8'h21, ack); chk("R8 read addr ack", 16'(ack), 16'h1);
        read_byte(1'b1, v); chk("R8 first byte", 16'(v), 16'h00A5);
        read_byte(1'b1, v); chk("R6 second byte", 16'(v), 16'h005A);
        read_byte(1'b0, v); chk("R6 third byte", 16'(v), 16'h00C3);
        waitc(4);
        chk("R6 released at end", 16'(sda_oe), 16'h0);
        bus_stop();
        chk("R8 no write", 16'(wcount - wbase), 16'h0);
        chk("R7 pointer after burst", rd_addr, 16'h1301);

        // R10 stop mid-byte
        wbase = wcount;
        bus_start();
        send_byte(8'h20, ack);
        send_byte(8'h00, ack);
        send_byte(8'h40, ack);
        send_bits(8'hF0, 4);
        bus_stop();
        chk("R10 no partial write on stop", 16'(wcount - wbase), 16'h0);
        chk("R10 pointer unchanged on stop", rd_addr, 16'h0040);

        // R10 start mid-byte
        bus_start();
        send_bits(8'h20, 4);
        bus_start();
        send_byte(8'h20, ack); chk("R10 addr after restart", 16'(ack), 16'h1);
        send_byte(8'h00, ack);
        send_byte(8'h41, ack);
        bus_stop();
        chk("R10 pointer after restart", rd_addr, 16'h0041);
        chk("R10 no write after restart", 16'(wcount - wbase), 16'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        waitc(WDOG);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule